// File: doc/BRIEF.md
# I2C Byte Data and Acknowledge Shifter

This block is the data path of an I2C byte engine. A CPU-visible data register and a hidden acknowledge flag are chained into one shift path of DATA_W+1 bits. Bits sampled from SDA enter the acknowledge flag on each SCL rising strobe. At the same time the flag moves into bit 0 of the data register, and the register moves one place toward its most significant bit. A one-bit output buffer drives SDA and is updated on SCL falling strobes. In transmit mode it carries the register's top bit. In receive mode it carries the acknowledge value supplied by the controller. SDA is treated as open drain: a 1 on `sda_o` means released.

The outgoing byte is shifted back in from the bus, so one register serves both directions. After a byte it holds what was actually on the wire. If arbitration is lost, the byte is therefore already correct for the switch to slave receiver. A bit counter is cleared by the controller at START. It raises `done_o` after the ninth rising strobe and holds the register frozen until `done_clr_i` is pulsed. The surrounding engine owns START/STOP generation, arbitration decisions and SCL timing.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset `data_o` is 0x00, `ack_o` is 0, `sda_o` is 1 (released) and `done_o` is 0.
- R2: On an accepted SCL rising strobe the sampled `sda_i` enters the acknowledge flag, and the old flag value enters `data_o[0]`. After nine such strobes `data_o` holds the first eight bus bits with the earliest one in bit 7, and `ack_o` holds the ninth bit.
- R3: A write accepted while idle (count 0) or while `done_o` is 1 updates `data_o` to `wr_data_i`, and `sda_o` to `wr_data_i[7]`, one cycle after the strobe.
- R4: In transmit mode (`rx_mode_i`=0), each falling strobe during the eight data bits drives `sda_o` with `data_o[7]`. The falling strobe that opens the ninth bit releases SDA (`sda_o`=1).
- R5: In receive mode (`rx_mode_i`=1), `sda_o` stays 1 during the eight data bits. The falling strobe after the eighth rising strobe drives `ack_send_i` (0 = acknowledge), and the falling strobe after the ninth releases SDA in either mode.
- R6: In transmit mode the sent bits are shifted back in through `sda_i`. After the byte, `data_o` equals the wired-AND of the driven and bus bits, which is the other master's byte after lost arbitration.
- R7: `done_o` becomes 1 one cycle after the ninth accepted rising strobe. `done_clr_i` or `start_i` clears it and returns the bit count to 0.
- R8: While `done_o` is 1, rising strobes are ignored: `data_o` and `ack_o` stay unchanged.
- R9: Writes are ignored while a byte is shifting (count 1 to 8). A write in the same cycle as a rising strobe at count 0 is also ignored.
- R10: `start_i` clears the bit count at any point in a byte and takes priority over a rising strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START seen; clears bit count and done |
| done_clr_i | input | 1 | Clears done and bit count |
| wr_en_i | input | 1 | CPU write strobe for the data register |
| wr_data_i | input | DATA_W | CPU write data |
| scl_rise_i | input | 1 | One-cycle SCL rising-edge strobe |
| scl_fall_i | input | 1 | One-cycle SCL falling-edge strobe |
| sda_i | input | 1 | Synchronised SDA level |
| rx_mode_i | input | 1 | 1 = receive byte, 0 = transmit byte |
| ack_send_i | input | 1 | Level driven in the acknowledge slot when receiving |
| sda_o | output | 1 | SDA drive, 1 = released |
| data_o | output | DATA_W | Data register read value |
| ack_o | output | 1 | Acknowledge bit captured in the hidden flag |
| done_o | output | 1 | Byte complete after nine rising strobes |

## Verification
A CPU write and an SCL rising strobe can arrive in the same cycle while the count is still 0, the moment the first bit of a byte is sampled. The bench provokes this right after clearing done, with a write of 0x00 and a rising strobe on sda 1. The write must lose: `data_o` must show the previous register shifted by one with the old acknowledge in bit 0, `ack_o` must take the new bus bit, and `sda_o` must stay released rather than follow the written MSB. A second overlap, a rising strobe while done is set, is judged by `data_o` and `ack_o` staying unchanged.

// File: rtl/i2c_shift_pkg.sv
package i2c_shift_pkg;
  typedef enum logic [1:0] {
    SLOT_DATA = 2'd0,
    SLOT_ACK  = 2'd1,
    SLOT_DONE = 2'd2
  } slot_e;
endpackage

// File: rtl/i2c_bit_ctr.sv
module i2c_bit_ctr
  import i2c_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  clr_i,
  input  logic  rise_i,
  output logic  done_o,
  output logic  busy_o,
  output slot_e slot_o
);
  localparam int BITS  = DATA_W + 1;
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (start_i || clr_i)       cnt_q <= '0;
    else if (rise_i && cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CNT_LAST);
  assign busy_o = (cnt_q != '0) && !done_o;

  always_comb begin
    if (cnt_q < CNT_ACK)       slot_o = SLOT_DATA;
    else if (cnt_q == CNT_ACK) slot_o = SLOT_ACK;
    else                       slot_o = SLOT_DONE;
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
  p_done_after_ninth_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && cnt_q == CNT_ACK && !start_i && !clr_i) |=> done_o);
  p_start_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_shift_chain.sv
module i2c_shift_chain #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              shift_i,
  input  logic              sda_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ack_o
);
  logic [DATA_W-1:0] data_q;
  logic              ack_q;

  // sda -> ack flag -> data[0] ... data[MSB]
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ack_q  <= 1'b0;
    end else if (load_i) begin
      data_q <= wr_data_i;
    end else if (shift_i) begin
      data_q <= {data_q[DATA_W-2:0], ack_q};
      ack_q  <= sda_i;
    end
  end

  assign data_o = data_q;
  assign ack_o  = ack_q;

  p_ack_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (ack_o == $past(sda_i)));
  p_load_excl_shift_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/i2c_sda_buf.sv
module i2c_sda_buf
  import i2c_shift_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  load_msb_i,
  input  logic  fall_i,
  input  slot_e slot_i,
  input  logic  rx_mode_i,
  input  logic  ack_send_i,
  input  logic  data_msb_i,
  output logic  sda_o
);
  logic buf_q, buf_d;

  always_comb begin
    buf_d = buf_q;
    if (load_i) buf_d = load_msb_i;
    else if (fall_i) begin
      unique case (slot_i)
        SLOT_DATA: buf_d = rx_mode_i ? 1'b1 : data_msb_i;
        SLOT_ACK:  buf_d = rx_mode_i ? ack_send_i : 1'b1;
        default:   buf_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) buf_q <= 1'b1;
    else         buf_q <= buf_d;
  end

  assign sda_o = buf_q;

  p_rx_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !load_i && rx_mode_i && slot_i == SLOT_DATA) |=> sda_o);
  p_done_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !load_i && slot_i == SLOT_DONE) |=> sda_o);
  p_tx_ack_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !load_i && !rx_mode_i && slot_i == SLOT_ACK) |=> sda_o);
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2c_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_clr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              rx_mode_i,
  input  logic              ack_send_i,
  output logic              sda_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ack_o,
  output logic              done_o
);
  logic  busy, done, shift, load;
  slot_e slot;

  i2c_bit_ctr #(.DATA_W(DATA_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .clr_i  (done_clr_i),
    .rise_i (scl_rise_i),
    .done_o (done),
    .busy_o (busy),
    .slot_o (slot)
  );

  // rise frozen while done; write loses to a rise that opens the byte
  assign shift = scl_rise_i && !done && !start_i && !done_clr_i;
  assign load  = wr_en_i && (done || (!busy && !scl_rise_i));

  i2c_shift_chain #(.DATA_W(DATA_W)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .wr_data_i(wr_data_i),
    .shift_i  (shift),
    .sda_i    (sda_i),
    .data_o   (data_o),
    .ack_o    (ack_o)
  );

  i2c_sda_buf u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_msb_i(wr_data_i[DATA_W-1]),
    .fall_i    (scl_fall_i),
    .slot_i    (slot),
    .rx_mode_i (rx_mode_i),
    .ack_send_i(ack_send_i),
    .data_msb_i(data_o[DATA_W-1]),
    .sda_o     (sda_o)
  );

  assign done_o = done;

  p_write_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy && !scl_rise_i) |=> $stable(data_o));
  p_hold_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !wr_en_i) |=> ($stable(data_o) && $stable(ack_o)));
  p_load_msb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && done) |=> (sda_o == $past(wr_data_i[DATA_W-1])));
endmodule

// File: tb/tb_i2c_byte_shifter.sv
module tb_i2c_byte_shifter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       start = 0, done_clr = 0, wr_en = 0, rise = 0, fall = 0;
  logic       sda_in = 1, rx_mode = 0, ack_send = 1;
  logic [7:0] wr_data = '0;
  logic       sda_out, ack, done;
  logic [7:0] data;
  int         errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_shifter #(.DATA_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_clr_i(done_clr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .scl_rise_i(rise), .scl_fall_i(fall),
    .sda_i(sda_in), .rx_mode_i(rx_mode), .ack_send_i(ack_send),
    .sda_o(sda_out), .data_o(data), .ack_o(ack), .done_o(done)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic pulse_start;
    start = 1; tick(); start = 0;
  endtask

  task automatic pulse_clr;
    done_clr = 1; tick(); done_clr = 0;
  endtask

  task automatic cpu_write(input logic [7:0] v);
    wr_en = 1; wr_data = v; tick(); wr_en = 0;
  endtask

  // one SCL bit: rise with wired-AND bus level, then fall
  task automatic step_bit(input logic bus_bit);
    sda_in = sda_out & bus_bit; rise = 1; tick(); rise = 0;
    fall = 1; tick(); fall = 0; sda_in = 1;
  endtask

  task automatic run_byte(input logic [7:0] bus, input logic bus_ack,
                          input logic [8:0] exp_drv, input string req);
    for (int i = 8; i >= 0; i--) begin
      chk(req, {7'd0, sda_out}, {7'd0, exp_drv[i]});
      step_bit(i == 0 ? bus_ack : bus[i-1]);
    end
  endtask

  task automatic t_reset;
    chk("R1 data", data, 8'h00);
    chk("R1 ack", {7'd0, ack}, 8'h00);
    chk("R1 sda", {7'd0, sda_out}, 8'h01);
    chk("R1 done", {7'd0, done}, 8'h00);
  endtask

  task automatic t_tx_byte;
    rx_mode = 0;
    pulse_start();
    cpu_write(8'hA5);
    chk("R3 data load", data, 8'hA5);
    chk("R3 sda msb", {7'd0, sda_out}, 8'h01);
    fall = 1; tick(); fall = 0;
    run_byte(8'hFF, 1'b0, {8'hA5, 1'b1}, "R4 tx drive");
    chk("R7 done", {7'd0, done}, 8'h01);
    chk("R2 data after byte", data, 8'hA5);
    chk("R2 ack captured", {7'd0, ack}, 8'h00);
    pulse_clr();
    chk("R7 done cleared", {7'd0, done}, 8'h00);
  endtask

  task automatic t_lost_arb;
    rx_mode = 0;
    pulse_start();
    cpu_write(8'hFF);
    run_byte(8'h3C, 1'b1, {8'hFF, 1'b1}, "R4 tx drive");
    chk("R6 bus byte", data, 8'h3C);
    chk("R2 ack", {7'd0, ack}, 8'h01);
    pulse_clr();
  endtask

  task automatic t_write_block;
    rx_mode = 0;
    pulse_start();
    cpu_write(8'h5A);
    for (int i = 0; i < 3; i++) step_bit(1'b1);
    cpu_write(8'h00);
    for (int i = 0; i < 6; i++) step_bit(1'b1);
    chk("R7 done", {7'd0, done}, 8'h01);
    chk("R9 write ignored mid-byte", data, 8'h5A);
    sda_in = 0; rise = 1; tick(); rise = 0; sda_in = 1;
    chk("R8 data frozen", data, 8'h5A);
    chk("R8 ack frozen", {7'd0, ack}, 8'h01);
    cpu_write(8'hC3);
    chk("R3 write while done", data, 8'hC3);
    chk("R3 sda msb", {7'd0, sda_out}, 8'h01);
    pulse_clr();
  endtask

  task automatic t_rx_byte;
    rx_mode = 1; ack_send = 0;
    pulse_start();
    fall = 1; tick(); fall = 0;
    run_byte(8'h96, 1'b1, {8'hFF, 1'b0}, "R5 rx drive");
    chk("R5 released after ninth", {7'd0, sda_out}, 8'h01);
    chk("R2 rx data", data, 8'h96);
    chk("R2 rx ack", {7'd0, ack}, 8'h00);
  endtask

  task automatic t_write_vs_rise;
    pulse_clr();
    wr_en = 1; wr_data = 8'h00; sda_in = 1; rise = 1;
    tick();
    wr_en = 0; rise = 0;
    chk("R9 write lost to rise", data, 8'h2C);
    chk("R9 ack took bus bit", {7'd0, ack}, 8'h01);
    chk("R9 sda not reloaded", {7'd0, sda_out}, 8'h01);
  endtask

  task automatic t_restart;
    rx_mode = 1; ack_send = 1;
    pulse_start();
    for (int i = 0; i < 4; i++) step_bit(1'b1);
    pulse_start();
    for (int i = 0; i < 8; i++) step_bit(1'b0);
    chk("R10 count restarted", {7'd0, done}, 8'h00);
    step_bit(1'b1);
    chk("R10 done after nine", {7'd0, done}, 8'h01);
    chk("R10 data", data, 8'h00);
    pulse_clr();
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_tx_byte();
        t_lost_arb();
        t_write_block();
        t_rx_byte();
        t_write_vs_rise();
        t_restart();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule